// File: doc/BRIEF.md
# ADC Sequencer and Result Register Front End

This block is the digital front end of a 10-bit successive-approximation converter, as seen from an 8-bit peripheral bus. It holds the conversion settings: input channel and reference selection, result alignment, enable, start, free-running mode, completion flag, interrupt enable and prescaler code. It times each conversion with a length counter that advances on a prescaled clock. The converter core is modelled by a 10-bit sample input, which is captured when each conversion ends.

Software sets the channel and alignment, enables the block and writes the start bit. It then polls the start bit, or waits for the interrupt, and reads the result as a high/low byte pair. A read of the low byte freezes the result registers until the high byte has also been read, so the two halves always come from the same conversion. Channel and reference changes made while a conversion is running are held back and only reach the analog side once that conversion completes. Alignment changes apply at once.

Top module: `adcif_top`

Register map, selected by the 2-bit address:

- 0, select: [4:0] channel, [6:5] reference, [7] left-align.
- 1, control: [7] enable, [6] start/busy, [5] free-run, [4] completion flag, [3] interrupt enable, [2:0] prescaler code.
- 2: result high byte.
- 3: result low byte.

## Requirements
- R1: With right alignment (select bit 7 = 0) the high byte reads {6'b0, result[9:8]} and the low byte reads result[7:0]. With left alignment (bit 7 = 1) the high byte reads result[9:2] and the low byte reads {result[1:0], 6'b0}.
- R2: A change of the alignment bit changes the bytes read back in the next cycle, even while a conversion is in progress.
- R3: The select register always reads back the value last written. The chan_o and ref_o outputs take a written value at once when idle, but a write made during a conversion reaches them only when that conversion completes.
- R4: Control bit 6 reads 1 from the cycle after a start until the conversion completes, then reads 0. Writing 0 to it has no effect. A start is a control write with bits 7 and 6 both set.
- R5: A normal conversion lasts 13 prescaled clocks. Prescaler code k (1 to 7) divides the system clock by 2^k, and code 0 behaves like code 1. With code 1 the start bit reads 1 for 26 cycles, and with code 2 for 52.
- R6: The first start after reset, or after the block has been disabled, runs an initialising conversion of 25 prescaled clocks followed by a normal one. The start bit stays 1 for all 38 (76 cycles with code 1). Later starts take the normal length.
- R7: A read strobe on address 3 locks the result registers, and a read strobe on address 2 unlocks them. A conversion that completes while they are locked is discarded, but the completion flag is still set.
- R8: With free-run (bit 5) set, one start produces back-to-back conversions. Clearing free-run lets the current conversion finish and then stops.
- R9: Clearing enable during a conversion aborts it: the start bit reads 0 on the next cycle, and no flag or result update follows.
- R10: The completion flag (bit 4) is set when a conversion updates or would update the result. It is cleared by writing 1 to bit 4 or by an irq_ack_i pulse. Writing 0 to bit 4 leaves it set.
- R11: irq_o is high exactly when the completion flag and the interrupt enable (bit 3) are both set.
- R12: After reset all four registers read 0, and chan_o, ref_o and irq_o are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset, asynchronous |
| bus_wr_i | input | 1 | Register write strobe |
| bus_rd_i | input | 1 | Register read strobe (drives the result lock) |
| bus_addr_i | input | 2 | Register address |
| bus_wdata_i | input | 8 | Write data |
| bus_rdata_o | output | 8 | Read data for the addressed register, combinational |
| sample_i | input | 10 | Converter core output, captured when a conversion ends |
| irq_ack_i | input | 1 | Interrupt acknowledge, clears the completion flag |
| chan_o | output | 5 | Active channel select to the analog mux |
| ref_o | output | 2 | Active reference select |
| irq_o | output | 1 | Interrupt request |

## Verification
Result formatting is driven with full-scale, zero, alternating-bit and single-high-bit samples in both alignments. These patterns tell apart a swapped byte, a shift by one and a missing zero fill. Conversion length is measured under several prescaler codes and for the first start versus later starts, which separates the divisor decode from the initialising extension. Select writes, alignment toggles, low-byte locking, disable and free-run exit are each applied in the middle of a running conversion, so that deferred and immediate effects can be distinguished.

// File: rtl/adcif_pkg.sv
package adcif_pkg;
  typedef enum logic [1:0] {
    A_SEL = 2'd0,
    A_CTL = 2'd1,
    A_RHI = 2'd2,
    A_RLO = 2'd3
  } reg_addr_e;

  localparam int CTL_EN  = 7;
  localparam int CTL_GO  = 6;
  localparam int CTL_FR  = 5;
  localparam int CTL_FLG = 4;
  localparam int CTL_IE  = 3;
endpackage

// File: rtl/adcif_prescale.sv
module adcif_prescale #(
  parameter int PS_W = 3
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            run_i,
  input  logic [PS_W-1:0] ps_i,
  output logic            tick_o
);
  localparam int CNT_W = (1 << PS_W) - 1;

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] mask;

  // divisor 2^k; code 0 aliases code 1
  always_comb begin
    if (ps_i == '0) mask = CNT_W'(1);
    else            mask = (CNT_W'(1) << ps_i) - CNT_W'(1);
  end

  assign tick_o = run_i && ((cnt_q & mask) == mask);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (!run_i) cnt_q <= '0;
    else             cnt_q <= cnt_q + CNT_W'(1);
  end

  // R5
  tick_spacing_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tick_o |=> !tick_o);
endmodule

// File: rtl/adcif_seq.sv
module adcif_seq #(
  parameter int NORM_LEN = 13,
  parameter int INIT_LEN = 25
) (
  input  logic clk,
  input  logic rst_n,
  input  logic en_i,
  input  logic start_i,
  input  logic free_i,
  input  logic tick_i,
  output logic busy_o,
  output logic done_o
);
  localparam int LEN_W = $clog2(INIT_LEN + 1);

  logic             busy_q, init_q, need_init_q;
  logic [LEN_W-1:0] cnt_q;
  logic             last;

  assign last   = tick_i && (cnt_q == (init_q ? LEN_W'(INIT_LEN - 1) : LEN_W'(NORM_LEN - 1)));
  assign done_o = busy_q && en_i && last && !init_q;
  assign busy_o = busy_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0; init_q <= 1'b0; need_init_q <= 1'b1; cnt_q <= '0;
    end else if (start_i && !busy_q) begin
      busy_q <= 1'b1; init_q <= need_init_q; need_init_q <= 1'b0; cnt_q <= '0;
    end else if (!en_i) begin
      busy_q <= 1'b0; init_q <= 1'b0; need_init_q <= 1'b1; cnt_q <= '0;
    end else if (busy_q && tick_i) begin
      if (last) begin
        cnt_q <= '0;
        if (init_q)       init_q <= 1'b0;
        else if (!free_i) busy_q <= 1'b0;
      end else begin
        cnt_q <= cnt_q + LEN_W'(1);
      end
    end
  end

  // R9
  abort_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && !en_i && !start_i) |=> !busy_q);
  // R4
  busy_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy_q) |-> ($past(done_o) || !$past(en_i)));
  // R8
  free_cont_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done_o && free_i) |=> busy_q);
endmodule

// File: rtl/adcif_result.sv
module adcif_result #(
  parameter int RES_W  = 10,
  parameter int BYTE_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              capture_i,
  input  logic [RES_W-1:0]  sample_i,
  input  logic              lock_set_i,
  input  logic              lock_clr_i,
  input  logic              left_i,
  output logic [BYTE_W-1:0] hi_o,
  output logic [BYTE_W-1:0] lo_o
);
  localparam int SPILL = RES_W - BYTE_W;

  logic [RES_W-1:0] res_q;
  logic             lock_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      res_q <= '0; lock_q <= 1'b0;
    end else begin
      if (capture_i && !lock_q) res_q <= sample_i;
      if (lock_clr_i)      lock_q <= 1'b0;
      else if (lock_set_i) lock_q <= 1'b1;
    end
  end

  always_comb begin
    if (left_i) begin
      hi_o = res_q[RES_W-1 -: BYTE_W];
      lo_o = {res_q[SPILL-1:0], {(BYTE_W-SPILL){1'b0}}};
    end else begin
      hi_o = BYTE_W'(res_q[RES_W-1:BYTE_W]);
      lo_o = res_q[BYTE_W-1:0];
    end
  end

  // R7
  locked_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    lock_q |=> $stable(res_q));
  // R7
  capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (capture_i && !lock_q) |=> (res_q == $past(sample_i)));
endmodule

// File: rtl/adcif_top.sv
module adcif_top #(
  parameter int RES_W    = 10,
  parameter int BYTE_W   = 8,
  parameter int CH_W     = 5,
  parameter int REF_W    = 2,
  parameter int PS_W     = 3,
  parameter int NORM_LEN = 13,
  parameter int INIT_LEN = 25
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             bus_wr_i,
  input  logic             bus_rd_i,
  input  logic [1:0]       bus_addr_i,
  input  logic [BYTE_W-1:0] bus_wdata_i,
  output logic [BYTE_W-1:0] bus_rdata_o,
  input  logic [RES_W-1:0] sample_i,
  input  logic             irq_ack_i,
  output logic [CH_W-1:0]  chan_o,
  output logic [REF_W-1:0] ref_o,
  output logic             irq_o
);
  import adcif_pkg::*;

  localparam int REF_LO   = CH_W;
  localparam int REF_HI   = CH_W + REF_W - 1;
  localparam int SEL_LEFT = BYTE_W - 1;

  reg_addr_e         addr;
  logic [CH_W-1:0]   sel_ch_q, act_ch_q;
  logic [REF_W-1:0]  sel_ref_q, act_ref_q;
  logic              left_q, en_q, free_q, ie_q, flag_q;
  logic [PS_W-1:0]   ps_q;
  logic              wr_sel, wr_ctl, start, busy, done, tick;
  logic [BYTE_W-1:0] res_hi, res_lo, rd_sel, rd_ctl;

  assign addr   = reg_addr_e'(bus_addr_i);
  assign wr_sel = bus_wr_i && (addr == A_SEL);
  assign wr_ctl = bus_wr_i && (addr == A_CTL);
  assign start  = wr_ctl && bus_wdata_i[CTL_EN] && bus_wdata_i[CTL_GO];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sel_ch_q <= '0; sel_ref_q <= '0; left_q <= 1'b0;
      act_ch_q <= '0; act_ref_q <= '0;
      en_q <= 1'b0; free_q <= 1'b0; ie_q <= 1'b0; ps_q <= '0; flag_q <= 1'b0;
    end else begin
      if (wr_sel) begin
        sel_ch_q  <= bus_wdata_i[CH_W-1:0];
        sel_ref_q <= bus_wdata_i[REF_HI:REF_LO];
        left_q    <= bus_wdata_i[SEL_LEFT];
      end
      if (!busy || done) begin
        act_ch_q  <= sel_ch_q;
        act_ref_q <= sel_ref_q;
      end
      if (wr_ctl) begin
        en_q   <= bus_wdata_i[CTL_EN];
        free_q <= bus_wdata_i[CTL_FR];
        ie_q   <= bus_wdata_i[CTL_IE];
        ps_q   <= bus_wdata_i[PS_W-1:0];
      end
      if (done)                                            flag_q <= 1'b1;
      else if (irq_ack_i || (wr_ctl && bus_wdata_i[CTL_FLG])) flag_q <= 1'b0;
    end
  end

  adcif_prescale #(.PS_W(PS_W)) u_pre (
    .clk(clk), .rst_n(rst_n), .run_i(busy), .ps_i(ps_q), .tick_o(tick));

  adcif_seq #(.NORM_LEN(NORM_LEN), .INIT_LEN(INIT_LEN)) u_seq (
    .clk(clk), .rst_n(rst_n), .en_i(en_q), .start_i(start), .free_i(free_q),
    .tick_i(tick), .busy_o(busy), .done_o(done));

  adcif_result #(.RES_W(RES_W), .BYTE_W(BYTE_W)) u_res (
    .clk(clk), .rst_n(rst_n), .capture_i(done), .sample_i(sample_i),
    .lock_set_i(bus_rd_i && (addr == A_RLO)),
    .lock_clr_i(bus_rd_i && (addr == A_RHI)),
    .left_i(left_q), .hi_o(res_hi), .lo_o(res_lo));

  always_comb begin
    rd_sel = '0;
    rd_sel[CH_W-1:0]     = sel_ch_q;
    rd_sel[REF_HI:REF_LO] = sel_ref_q;
    rd_sel[SEL_LEFT]     = left_q;
    rd_ctl = '0;
    rd_ctl[CTL_EN]  = en_q;
    rd_ctl[CTL_GO]  = busy;
    rd_ctl[CTL_FR]  = free_q;
    rd_ctl[CTL_FLG] = flag_q;
    rd_ctl[CTL_IE]  = ie_q;
    rd_ctl[PS_W-1:0] = ps_q;
    case (addr)
      A_SEL:   bus_rdata_o = rd_sel;
      A_CTL:   bus_rdata_o = rd_ctl;
      A_RHI:   bus_rdata_o = res_hi;
      default: bus_rdata_o = res_lo;
    endcase
  end

  assign chan_o = act_ch_q;
  assign ref_o  = act_ref_q;
  assign irq_o  = flag_q && ie_q;

  // R3
  sel_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !done) |=> $stable({act_ch_q, act_ref_q}));
  // R10
  flag_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flag_q) |-> $past(done));
  // R10
  ack_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_ack_i && !done) |=> !flag_q);
  // R11
  irq_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !ie_q |-> !irq_o);
endmodule

// File: tb/sim_adcif_top.sv
module sim_adcif_top;
  localparam int CLK_NS = 10;
  localparam int NVEC = 6;
  // {sample, left, expected high, expected low}
  localparam logic [26:0] VEC [NVEC] = '{
    {10'h3FF, 1'b0, 8'h03, 8'hFF},
    {10'h3FF, 1'b1, 8'hFF, 8'hC0},
    {10'h2A5, 1'b0, 8'h02, 8'hA5},
    {10'h2A5, 1'b1, 8'hA9, 8'h40},
    {10'h15A, 1'b1, 8'h56, 8'h80},
    {10'h201, 1'b1, 8'h80, 8'h40}
  };

  logic clk = 1'b0, rst_n = 1'b0;
  logic bus_wr = 1'b0, bus_rd = 1'b0, irq_ack = 1'b0;
  logic [1:0] bus_addr = 2'd0;
  logic [7:0] bus_wdata = 8'h00, bus_rdata;
  logic [9:0] sample = 10'h000;
  logic [4:0] chan;
  logic [1:0] refsel;
  logic irq;
  int checks = 0, fails = 0;

  always #(CLK_NS/2) clk = ~clk;

  adcif_top u0 (
    .clk(clk), .rst_n(rst_n), .bus_wr_i(bus_wr), .bus_rd_i(bus_rd),
    .bus_addr_i(bus_addr), .bus_wdata_i(bus_wdata), .bus_rdata_o(bus_rdata),
    .sample_i(sample), .irq_ack_i(irq_ack), .chan_o(chan), .ref_o(refsel), .irq_o(irq));

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk); bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk); bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a);
    @(negedge clk); bus_rd = 1'b1; bus_addr = a;
    @(negedge clk); bus_rd = 1'b0;
  endtask

  task automatic peek(input logic [1:0] a, output logic [7:0] d);
    @(negedge clk); bus_addr = a; #1 d = bus_rdata;
  endtask

  task automatic wait_idle(output int n);
    logic [7:0] d;
    n = 0;
    do begin peek(2'd1, d); n++; end while (d[6] && n < 5000);
  endtask

  task automatic wait_flag();
    logic [7:0] d;
    int n = 0;
    do begin peek(2'd1, d); n++; end while (!d[4] && n < 5000);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  initial begin
    #(CLK_NS * 150000);
    checks++; fails++;
    $display("FAIL watchdog expired");
    summary();
  end

  initial begin
    logic [7:0] d;
    int n;
    idle(3); rst_n = 1'b1;

    // R12 reset state
    for (int a = 0; a < 4; a++) begin
      peek(2'(a), d); chk("R12 reg reset", d, 8'h00);
    end
    chk("R12 outputs reset", {chan, refsel, irq}, 0);

    // R6 start together with enable: extended
    wr(2'd1, 8'hC1); wait_idle(n); chk("R6 first conversion length", n, 76);
    // R5 normal lengths under several prescaler codes
    wr(2'd1, 8'hC1); wait_idle(n); chk("R5 code1 length", n, 26);
    wr(2'd1, 8'hC2); wait_idle(n); chk("R5 code2 length", n, 52);
    wr(2'd1, 8'hC0); wait_idle(n); chk("R5 code0 length", n, 26);

    // R1 vector table
    for (int i = 0; i < NVEC; i++) begin
      sample = VEC[i][26:17];
      wr(2'd0, {VEC[i][16], 7'b0});
      wr(2'd1, 8'hC1); wait_idle(n);
      peek(2'd2, d); chk("R1 high byte", d, VEC[i][15:8]);
      peek(2'd3, d); chk("R1 low byte", d, VEC[i][7:0]);
    end

    // R10 flag set, write 0 keeps, write 1 clears, ack clears
    peek(2'd1, d); chk("R10 flag set", d[4], 1);
    wr(2'd1, 8'h81); peek(2'd1, d); chk("R10 write zero keeps flag", d[4], 1);
    wr(2'd1, 8'h91); peek(2'd1, d); chk("R10 write one clears flag", d[4], 0);
    wr(2'd1, 8'hC1); wait_idle(n);
    @(negedge clk); irq_ack = 1'b1; @(negedge clk); irq_ack = 1'b0;
    peek(2'd1, d); chk("R10 ack clears flag", d[4], 0);

    // R11 interrupt gating
    wr(2'd1, 8'hC9); wait_idle(n); chk("R11 irq with enable", irq, 1);
    wr(2'd1, 8'h81); chk("R11 irq masked", irq, 0);
    wr(2'd1, 8'h99); chk("R11 irq after clear", irq, 0);

    // R2 alignment live
    sample = 10'h2A5; wr(2'd0, 8'h00); wr(2'd1, 8'hC1); wait_idle(n);
    wr(2'd0, 8'h80); peek(2'd2, d); chk("R2 realign idle", d, 8'hA9);
    wr(2'd1, 8'hC1); idle(3);
    wr(2'd0, 8'h00); peek(2'd2, d); chk("R2 realign while busy", d, 8'h02);
    peek(2'd1, d); chk("R2 still busy", d[6], 1);
    wait_idle(n);

    // R3 deferred select
    wr(2'd0, 8'h03); idle(1); chk("R3 idle select applies", chan, 5'd3);
    wr(2'd1, 8'hC1); idle(2);
    wr(2'd0, 8'h45); idle(2);
    chk("R3 held during conversion", {refsel, chan}, {2'd0, 5'd3});
    peek(2'd0, d); chk("R3 readback shows written", d, 8'h45);
    wait_idle(n);
    chk("R3 applied after completion", {refsel, chan}, {2'd2, 5'd5});

    // R4 writing zero to start has no effect
    wr(2'd1, 8'hC1); idle(2); wr(2'd1, 8'h81);
    peek(2'd1, d); chk("R4 start stays high", d[6], 1);
    wait_idle(n); chk("R4 start returns low", n > 0 && n < 26, 1);

    // R7 low-byte lock
    wr(2'd0, 8'h00); sample = 10'h155; wr(2'd1, 8'hD1); wait_idle(n);
    rd(2'd3);
    sample = 10'h0AA; wr(2'd1, 8'hD1); wait_idle(n);
    peek(2'd1, d); chk("R7 flag set while locked", d[4], 1);
    peek(2'd3, d); chk("R7 locked low kept", d, 8'h55);
    peek(2'd2, d); chk("R7 locked high kept", d, 8'h01);
    rd(2'd2);
    wr(2'd1, 8'hD1); wait_idle(n);
    peek(2'd3, d); chk("R7 unlocked capture", d, 8'hAA);

    // R8 free-running
    wr(2'd1, 8'h91);
    wr(2'd1, 8'hE1); wait_flag();
    peek(2'd1, d); chk("R8 continues after first", d[6], 1);
    wr(2'd1, 8'hB1); wait_flag();
    peek(2'd1, d); chk("R8 second conversion flag", d[4], 1);
    wr(2'd1, 8'h91); wait_idle(n); chk("R8 stops within one conversion", n <= 26, 1);
    idle(60); peek(2'd1, d); chk("R8 stays stopped", d[6], 0);

    // R9 abort, then R6 extended again
    sample = 10'h3FF; wr(2'd1, 8'hD1); idle(5);
    wr(2'd1, 8'h01); peek(2'd1, d); chk("R9 aborted busy", d[6], 0);
    idle(80); peek(2'd1, d); chk("R9 no flag", d[4], 0);
    peek(2'd3, d); chk("R9 no capture", d, 8'hAA);
    wr(2'd1, 8'hC1); wait_idle(n); chk("R6 extended after re-enable", n, 76);

    summary();
  end
endmodule